// File: doc/BRIEF.md
# Buck Start-Up and Fault Sequencer

This block is the digital sequencer that sits beside the analog loop of a synchronous step-down converter. It takes already-digitized comparator flags and decides when the converter may switch. The flags are supply-good, enable, phase above the detection level, phase below the discharge level, and feedback over-voltage and under-voltage. The comparators, the reference and the gate drivers stay outside. The regulation loop's own pulse-width decisions are gated by `pwm_en`. `hs_force` and `ls_force` let the sequencer drive the gates directly when it needs to.

Start-up has three phases. First comes a probe phase: short high-side pulses at a fixed rate, with the low side held off, check that input voltage is present. Next an internal ramp code rises from zero to the reference code, and a configuration bit can halve the current limit during that ramp. Last, a blanking interval runs before the open-drain power-good is released.

Over-voltage that persists past its qualification window is latched with the low side forced on. Only a drop of enable or of supply-good clears it. Under-voltage is watched only once the ramp has finished. Once qualified, it turns both gates off for a hiccup interval and then restarts the ramp without a new probe phase. Losing enable or supply-good stops switching at once and starts a discharge mode. In that mode the low side is pulsed and a feedback-to-ground switch is closed until the phase flag reports a low level. All analog flags pass through two-flop synchronizers. Every interval is a parameter in clock cycles.

Top module: `buck_seq_supervisor`

## Requirements
- R1: After reset, `pwm_en`, `hs_force`, `ls_force`, `dis_sw` and `ocp_half` are 0, `ss_code` is 0 and `pg_pull` is 1 (power-good pulled low).
- R2: With supply-good and enable both high, the probe phase drives `hs_force` high for DET_PULSE cycles at the start of every DET_PERIOD-cycle window. During this phase `ls_force` and `pwm_en` stay 0.
- R3: `phase_det_a` is sampled in the last cycle of each probe window. The ramp starts only after DET_PASS+1 consecutive samples read 0. A sample reading 1 restarts the count. While the flag stays 1, the probe phase never ends.
- R4: When the ramp starts, `pwm_en` goes to 1 and `ss_code` counts up from 0 by one every SS_STEP cycles. It stops at REF_CODE, which it reaches REF_CODE*SS_STEP cycles after the ramp start.
- R5: `ocp_half` equals `ocp_halve_cfg` while the ramp is rising and is 0 at all other times.
- R6: `pg_pull` goes to 0 only after BLANK_CYC cycles have followed the end of the ramp, and only while neither synchronized `fb_ov_a` nor synchronized `fb_uv_a` is 1. In every other state it is 1.
- R7: Over-voltage trips only after `fb_ov_a` stays high for OV_QUAL consecutive synchronized cycles. A shorter pulse has no effect. A trip sets `pwm_en` to 0 and `ls_force` to 1.
- R8: After an over-voltage trip, `ls_force` stays 1 and `pwm_en` stays 0 even when `fb_ov_a` returns low. Only a low level on `enable_a` or `por_ok_a` leaves this state. Afterwards a new probe phase starts.
- R9: `fb_uv_a` has no effect while the ramp is rising. Once the ramp has finished, UV_QUAL consecutive cycles of under-voltage set `pwm_en`, `hs_force` and `ls_force` to 0 for HICCUP_CYC cycles. The ramp then restarts from 0 with no probe pulses.
- R10: When `enable_a` or `por_ok_a` goes low in any active state, `pwm_en` drops within 3 cycles and `dis_sw` goes to 1. `ls_force` is then high for DIS_PULSE cycles in every DIS_PERIOD-cycle window. This continues until `phase_low_a` is 1, after which `dis_sw` and `ls_force` return to 0.
- R11: `hs_force` is never 1 together with `ls_force` or with `pwm_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok_a | input | 1 | Supply above power-on threshold (asynchronous) |
| enable_a | input | 1 | Enable request (asynchronous) |
| phase_det_a | input | 1 | Phase node above input-detection level (asynchronous) |
| phase_low_a | input | 1 | Phase node below discharge-complete level (asynchronous) |
| fb_ov_a | input | 1 | Feedback above over-voltage threshold (asynchronous) |
| fb_uv_a | input | 1 | Feedback below under-voltage threshold (asynchronous) |
| ocp_halve_cfg | input | 1 | Static: halve current limit during the ramp |
| pwm_en | output | 1 | Regulation loop may switch |
| hs_force | output | 1 | Force high-side gate on |
| ls_force | output | 1 | Force low-side gate on |
| ss_code | output | SS_W | Soft-start ramp code for the reference |
| ocp_half | output | 1 | Current-limit threshold halved |
| dis_sw | output | 1 | Feedback-to-ground discharge switch on |
| pg_pull | output | 1 | Power-good open-drain pull-down active |

## Verification
A wrong state in this sequencer shows up at the gate commands within a few cycles. Examples are a missed latch, a qualification counter that does not restart, or a hiccup that passes through probing. Such faults appear as `pwm_en` rising or falling outside its window, `ls_force` releasing after an over-voltage, or `hs_force` pulses where none belong. The timing of each transition is measured against windows derived from the parameters: probe count, ramp length, blanking, qualification and hiccup off-time. Power-good and the current-limit scale are sampled at points on both sides of their expected edges, so a shifted interval is visible within one blanking or ramp period.

// File: rtl/bsv_pkg.sv
package bsv_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_DETECT,
    ST_SOFT,
    ST_BLANK,
    ST_RUN,
    ST_OVLATCH,
    ST_HICCUP,
    ST_DISCH
  } sup_state_e;
endpackage

// File: rtl/bsv_sync.sv
module bsv_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      logic meta;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta <= 1'b0;
          q[i] <= 1'b0;
        end else begin
          meta <= d[i];
          q[i] <= meta;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/bsv_qual.sv
module bsv_qual #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!flag)               cnt <= '0;
    else if (cnt != CW'(LIMIT))   cnt <= cnt + 1'b1;
  end

  assign hit = flag && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/bsv_pulse.sv
module bsv_pulse #(
  parameter int PERIOD = 40,
  parameter int WIDTH  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic on,
  output logic last
);
  localparam int CW = $clog2(PERIOD);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (!run)                      cnt <= '0;
    else if (cnt == CW'(PERIOD - 1))    cnt <= '0;
    else                                cnt <= cnt + 1'b1;
  end

  assign on   = run && (cnt < CW'(WIDTH));
  assign last = run && (cnt == CW'(PERIOD - 1));
endmodule

// File: rtl/bsv_ramp.sv
module bsv_ramp #(
  parameter int W      = 8,
  parameter int STEP   = 4,
  parameter int TARGET = 200
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clear,
  output logic [W-1:0] code,
  output logic         done
);
  localparam int SW = $clog2(STEP + 1);
  logic [SW-1:0] sub;

  assign done = (code == W'(TARGET));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
      sub  <= '0;
    end else if (clear) begin
      code <= '0;
      sub  <= '0;
    end else if (run && !done) begin
      if (sub == SW'(STEP - 1)) begin
        sub  <= '0;
        code <= code + 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end
endmodule

// File: rtl/buck_seq_supervisor.sv
module buck_seq_supervisor
  import bsv_pkg::*;
#(
  parameter int DET_PERIOD = 40,
  parameter int DET_PULSE  = 3,
  parameter int DET_PASS   = 3,
  parameter int SS_W       = 8,
  parameter int SS_STEP    = 4,
  parameter int REF_CODE   = 200,
  parameter int BLANK_CYC  = 400,
  parameter int OV_QUAL    = 16,
  parameter int UV_QUAL    = 16,
  parameter int HICCUP_CYC = 3000,
  parameter int DIS_PERIOD = 20,
  parameter int DIS_PULSE  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            por_ok_a,
  input  logic            enable_a,
  input  logic            phase_det_a,
  input  logic            phase_low_a,
  input  logic            fb_ov_a,
  input  logic            fb_uv_a,
  input  logic            ocp_halve_cfg,
  output logic            pwm_en,
  output logic            hs_force,
  output logic            ls_force,
  output logic [SS_W-1:0] ss_code,
  output logic            ocp_half,
  output logic            dis_sw,
  output logic            pg_pull
);
  localparam int TMAX = (BLANK_CYC > HICCUP_CYC) ? BLANK_CYC : HICCUP_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int DW   = $clog2(DET_PASS + 2);
  localparam int NF   = 6;

  // synchronized analog flags
  logic [NF-1:0] raw_f, syn_f;
  logic por_s, en_s, det_s, low_s, ov_s, uv_s;
  assign raw_f = {por_ok_a, enable_a, phase_det_a, phase_low_a, fb_ov_a, fb_uv_a};

  bsv_sync #(.W(NF)) u_sync (.clk(clk), .rst_n(rst_n), .d(raw_f), .q(syn_f));
  assign {por_s, en_s, det_s, low_s, ov_s, uv_s} = syn_f;

  sup_state_e state_q, state_d;
  logic [TW-1:0] tmr;
  logic [DW-1:0] pass_cnt;

  logic regulating, uv_window;
  assign regulating = (state_q == ST_SOFT) || (state_q == ST_BLANK) || (state_q == ST_RUN);
  assign uv_window  = (state_q == ST_BLANK) || (state_q == ST_RUN);

  // fault qualification
  logic ov_hit, uv_hit;
  bsv_qual #(.LIMIT(OV_QUAL)) u_ovq (.clk(clk), .rst_n(rst_n), .flag(ov_s && regulating), .hit(ov_hit));
  bsv_qual #(.LIMIT(UV_QUAL)) u_uvq (.clk(clk), .rst_n(rst_n), .flag(uv_s && uv_window),  .hit(uv_hit));

  // probe and discharge pulse trains
  logic det_on, det_last, dis_on, dis_last;
  bsv_pulse #(.PERIOD(DET_PERIOD), .WIDTH(DET_PULSE)) u_detp (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_DETECT), .on(det_on), .last(det_last));
  bsv_pulse #(.PERIOD(DIS_PERIOD), .WIDTH(DIS_PULSE)) u_disp (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_DISCH), .on(dis_on), .last(dis_last));

  // soft-start ramp
  logic ramp_done;
  bsv_ramp #(.W(SS_W), .STEP(SS_STEP), .TARGET(REF_CODE)) u_ramp (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_SOFT), .clear(!regulating),
    .code(ss_code), .done(ramp_done));

  always_comb begin
    state_d = state_q;
    if (!(por_s && en_s) && (state_q != ST_OFF) && (state_q != ST_DISCH)) begin
      state_d = ST_DISCH;
    end else begin
      unique case (state_q)
        ST_OFF:     if (por_s && en_s) state_d = ST_DETECT;
        ST_DETECT:  if (det_last && !det_s && (pass_cnt == DW'(DET_PASS))) state_d = ST_SOFT;
        ST_SOFT: begin
          if (ov_hit)         state_d = ST_OVLATCH;
          else if (ramp_done) state_d = ST_BLANK;
        end
        ST_BLANK: begin
          if (ov_hit)                            state_d = ST_OVLATCH;
          else if (uv_hit)                       state_d = ST_HICCUP;
          else if (tmr == TW'(BLANK_CYC - 1))    state_d = ST_RUN;
        end
        ST_RUN: begin
          if (ov_hit)      state_d = ST_OVLATCH;
          else if (uv_hit) state_d = ST_HICCUP;
        end
        ST_OVLATCH: state_d = ST_OVLATCH;
        ST_HICCUP:  if (tmr == TW'(HICCUP_CYC - 1)) state_d = ST_SOFT;
        ST_DISCH:   if (low_s) state_d = ST_OFF;
        default:    state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      tmr     <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q)     tmr <= '0;
      else if (tmr != TW'(TMAX))  tmr <= tmr + 1'b1;
    end
  end

  // consecutive clean probe samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pass_cnt <= '0;
    else if (state_q != ST_DETECT)    pass_cnt <= '0;
    else if (det_last) begin
      if (det_s)                          pass_cnt <= '0;
      else if (pass_cnt != DW'(DET_PASS)) pass_cnt <= pass_cnt + 1'b1;
    end
  end

  assign pwm_en   = regulating;
  assign hs_force = (state_q == ST_DETECT) && det_on;
  assign ls_force = (state_q == ST_OVLATCH) || ((state_q == ST_DISCH) && dis_on);
  assign dis_sw   = (state_q == ST_DISCH);
  assign ocp_half = ocp_halve_cfg && (state_q == ST_SOFT);
  assign pg_pull  = !((state_q == ST_RUN) && !ov_s && !uv_s);

  logic unused_ok;
  assign unused_ok = dis_last;
endmodule

// File: rtl/bsv_checker.sv
module bsv_checker #(
  parameter int SS_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pwm_en,
  input logic            hs_force,
  input logic            ls_force,
  input logic [SS_W-1:0] ss_code,
  input logic            ocp_half,
  input logic            dis_sw,
  input logic            pg_pull
);
  a_r11_gates_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    hs_force |-> (!ls_force && !pwm_en));

  a_r6_pg_only_regulating: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_pull |-> (pwm_en && !dis_sw));

  a_r8_ov_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_force && !dis_sw) |=> (ls_force || dis_sw));

  a_r5_ocp_only_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    ocp_half |-> (pwm_en && pg_pull));

  a_r4_ramp_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && $past(pwm_en)) |-> (ss_code >= $past(ss_code)));

  a_r10_discharge_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dis_sw |-> (!pwm_en && !hs_force));
endmodule

bind buck_seq_supervisor bsv_checker #(.SS_W(SS_W)) u_bsv_chk (
  .clk(clk), .rst_n(rst_n), .pwm_en(pwm_en), .hs_force(hs_force),
  .ls_force(ls_force), .ss_code(ss_code), .ocp_half(ocp_half),
  .dis_sw(dis_sw), .pg_pull(pg_pull));

// File: tb/buck_seq_supervisor_tb_top.sv
`timescale 1ns/1ps
module buck_seq_supervisor_tb_top;
  localparam int P_DET  = 40;
  localparam int W_DET  = 3;
  localparam int N_PASS = 3;
  localparam int STEP   = 4;
  localparam int REFC   = 200;
  localparam int BLANK  = 400;
  localparam int OVQ    = 16;
  localparam int UVQ    = 16;
  localparam int HIC    = 3000;
  localparam int P_DIS  = 20;
  localparam int W_DIS  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_ok_a = 0, enable_a = 0, phase_det_a = 1, phase_low_a = 0;
  logic fb_ov_a = 0, fb_uv_a = 0, ocp_halve_cfg = 1;
  logic pwm_en, hs_force, ls_force, ocp_half, dis_sw, pg_pull;
  logic [7:0] ss_code;

  int checks = 0;
  int fails = 0;
  int r11_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  buck_seq_supervisor #(
    .DET_PERIOD(P_DET), .DET_PULSE(W_DET), .DET_PASS(N_PASS), .SS_W(8),
    .SS_STEP(STEP), .REF_CODE(REFC), .BLANK_CYC(BLANK), .OV_QUAL(OVQ),
    .UV_QUAL(UVQ), .HICCUP_CYC(HIC), .DIS_PERIOD(P_DIS), .DIS_PULSE(W_DIS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .por_ok_a(por_ok_a), .enable_a(enable_a),
    .phase_det_a(phase_det_a), .phase_low_a(phase_low_a), .fb_ov_a(fb_ov_a),
    .fb_uv_a(fb_uv_a), .ocp_halve_cfg(ocp_halve_cfg), .pwm_en(pwm_en),
    .hs_force(hs_force), .ls_force(ls_force), .ss_code(ss_code),
    .ocp_half(ocp_half), .dis_sw(dis_sw), .pg_pull(pg_pull));

  always @(negedge clk)
    if (rst_n && ((hs_force && ls_force) || (hs_force && pwm_en))) r11_bad++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic sig(input int w);
    case (w)
      0: return hs_force;
      1: return ls_force;
      2: return pwm_en;
      3: return dis_sw;
      default: return pg_pull;
    endcase
  endfunction

  // waits until signal w equals v, returns cycles waited (lim+1 on timeout)
  task automatic wait_sig(input int w, input logic v, input int lim, output int n);
    n = 0;
    while (sig(w) !== v && n <= lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset;
    tick(5); rst_n = 1; tick(3);
    chk(!pwm_en && !hs_force && !ls_force && !dis_sw && !ocp_half, "R1 commands off", 
        int'({pwm_en, hs_force, ls_force, dis_sw, ocp_half}), 0);
    chk(pg_pull && ss_code == 0, "R1 pgood low, ramp zero", int'(ss_code), 0);
  endtask

  task automatic t_probe;
    int n, w, lo;
    bit ls_seen;
    por_ok_a = 1; enable_a = 1;
    wait_sig(0, 1'b1, 3 * P_DET, n);
    chk(n <= 3 * P_DET, "R2 probe pulse appears", n, 3 * P_DET);
    w = 0; ls_seen = 0;
    while (hs_force && w < 100) begin ls_seen |= ls_force; tick(1); w++; end
    chk(w == W_DET, "R2 probe pulse width", w, W_DET);
    lo = 0;
    while (!hs_force && lo < 200) begin ls_seen |= ls_force | pwm_en; tick(1); lo++; end
    chk(lo == P_DET - W_DET, "R2 probe pulse gap", lo, P_DET - W_DET);
    chk(!ls_seen, "R2 low side and loop idle while probing", int'(ls_seen), 0);
    tick(10 * P_DET);
    chk(!pwm_en, "R3 no ramp while phase flag high", int'(pwm_en), 0);
  endtask

  task automatic t_detect_pass;
    int n;
    phase_det_a = 0; tick(2 * P_DET);
    phase_det_a = 1; tick(P_DET + 2);
    chk(!pwm_en, "R3 two clean windows not enough", int'(pwm_en), 0);
    phase_det_a = 0;
    wait_sig(2, 1'b1, 10 * P_DET, n);
    chk(n >= N_PASS * P_DET && n <= (N_PASS + 1) * P_DET + 5,
        "R3 ramp after DET_PASS+1 clean samples", n, (N_PASS + 1) * P_DET);
  endtask

  task automatic t_ramp(input bit cfg_expect);
    int n;
    chk(ocp_half == cfg_expect, "R5 ocp scale during ramp", int'(ocp_half), int'(cfg_expect));
    chk(ss_code <= 1, "R4 ramp starts at zero", int'(ss_code), 0);
    n = 0;
    fb_uv_a = 1;
    while (ss_code != REFC && n < REFC * STEP + 50) begin
      if (n == REFC * STEP / 2) begin
        chk(pwm_en, "R9 under-voltage ignored during ramp", int'(pwm_en), 1);
        fb_uv_a = 0;
      end
      tick(1); n++;
    end
    chk(n >= REFC * STEP - 4 && n <= REFC * STEP + 4, "R4 ramp length", n, REFC * STEP);
    tick(3);
    chk(ocp_half == 0, "R5 ocp scale off after ramp", int'(ocp_half), 0);
    chk(ss_code == REFC, "R4 ramp holds at reference", int'(ss_code), REFC);
    tick(BLANK - 12);
    chk(pg_pull, "R6 pgood held low in blanking", int'(pg_pull), 1);
    tick(20);
    chk(!pg_pull, "R6 pgood released after blanking", int'(pg_pull), 0);
  endtask

  task automatic t_ov_glitch;
    fb_ov_a = 1; tick(5);
    chk(pg_pull, "R6 pgood pulled on over-voltage flag", int'(pg_pull), 1);
    tick(OVQ - 11); fb_ov_a = 0; tick(10);
    chk(pwm_en && !ls_force, "R7 short over-voltage ignored", int'(ls_force), 0);
  endtask

  task automatic t_uv_hiccup;
    int n;
    bit hs_seen;
    fb_uv_a = 1;
    wait_sig(2, 1'b0, 10 * UVQ, n);
    chk(n >= UVQ && n <= UVQ + 4, "R9 under-voltage qualification", n, UVQ);
    fb_uv_a = 0;
    chk(!hs_force && !ls_force, "R9 gates off in hiccup", int'({hs_force, ls_force}), 0);
    n = 0; hs_seen = 0;
    while (!pwm_en && n < HIC + 100) begin hs_seen |= hs_force; tick(1); n++; end
    chk(n >= HIC - 4 && n <= HIC + 4, "R9 hiccup off-time", n, HIC);
    chk(!hs_seen, "R9 no probe on retry", int'(hs_seen), 0);
    chk(ss_code <= 1, "R9 ramp restarts from zero", int'(ss_code), 0);
    wait_sig(4, 1'b0, REFC * STEP + BLANK + 50, n);
    chk(!pg_pull, "R9 back in regulation after retry", int'(pg_pull), 0);
  endtask

  task automatic t_ov_latch;
    int n, w;
    fb_ov_a = 1;
    wait_sig(1, 1'b1, 10 * OVQ, n);
    chk(n >= OVQ && n <= OVQ + 4, "R7 over-voltage qualification", n, OVQ);
    chk(!pwm_en && pg_pull, "R7 loop off, pgood low on trip", int'(pwm_en), 0);
    fb_ov_a = 0; tick(200);
    chk(ls_force && !pwm_en, "R8 latch holds after flag clears", int'(ls_force), 1);
    enable_a = 0; tick(3);
    chk(dis_sw && !pwm_en, "R10 discharge on enable drop", int'(dis_sw), 1);
    wait_sig(1, 1'b0, 2 * P_DIS, n);
    wait_sig(1, 1'b1, 2 * P_DIS, n);
    chk(n == P_DIS - W_DIS, "R10 discharge pulse gap", n, P_DIS - W_DIS);
    w = 0;
    while (ls_force && w < 100) begin tick(1); w++; end
    chk(w == W_DIS, "R10 discharge pulse width", w, W_DIS);
    phase_low_a = 1; tick(4);
    chk(!dis_sw && !ls_force, "R10 discharge ends at low phase", int'({dis_sw, ls_force}), 0);
    phase_low_a = 0; phase_det_a = 1; enable_a = 1;
    wait_sig(0, 1'b1, 2 * P_DET, n);
    chk(n <= 2 * P_DET, "R8 enable toggle clears latch, probe restarts", n, 2 * P_DET);
  endtask

  task automatic t_por_loss;
    int n;
    ocp_halve_cfg = 0;
    phase_det_a = 0;
    wait_sig(2, 1'b1, 10 * P_DET, n);
    tick(5);
    chk(!ocp_half, "R5 no halving with config clear", int'(ocp_half), 0);
    por_ok_a = 0; tick(3);
    chk(!pwm_en && dis_sw, "R10 supply loss stops switching", int'(pwm_en), 0);
    phase_low_a = 1; tick(4);
    chk(!dis_sw && !ls_force && !pwm_en, "R10 idle after discharge", int'(dis_sw), 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_probe();
    t_detect_pass();
    t_ramp(1'b1);
    t_ov_glitch();
    t_uv_hiccup();
    t_ov_latch();
    t_por_loss();
    chk(r11_bad == 0, "R11 gate exclusivity", r11_bad, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule